// File: doc/BRIEF.md
# Two-cycle 8x8 multiplier

This block is the multiply unit of an 8-bit processor datapath. A start strobe loads two 8-bit operands and a 2-bit mode. The 16-bit product follows a fixed two cycles later. The product is split into a low byte and a high byte. The register-file write logic stores the low byte in register 0 and the high byte in register 1. The block also produces the zero and carry status flags for the operation. It computes no other flag.

Four modes are provided:
- unsigned by unsigned;
- signed by signed;
- signed first operand by unsigned second operand;
- fractional, which is an unsigned multiply followed by a left shift of one bit.

A new start is accepted in any cycle in which the unit is not busy. This includes the cycle in which the previous result is reported. Back-to-back operations therefore run at one result every two cycles.

Top module: `mul8x8_core`

## Requirements
- R1: A start accepted in cycle n (start_i high while busy_o is low) drives busy_o high in cycle n+1 only, and done_o high in cycle n+2 only, together with that operation's result and flags.
- R2: A start_i in a cycle where busy_o is high is ignored. The operands and mode presented in that cycle do not affect the result of the operation already in flight.
- R3: The 16-bit result is split as follows: prod_hi_o carries bits 15..8 (register 1) and prod_lo_o carries bits 7..0 (register 0).
- R4: When mode_i is 2'b00, the result is the unsigned product of op_a_i and op_b_i.
- R5: When mode_i is 2'b01, the result is the two's-complement product of the two operands, both taken as signed, truncated to 16 bits.
- R6: When mode_i is 2'b10, op_a_i is taken as signed and op_b_i as unsigned. The result is their product, truncated to 16 bits.
- R7: When mode_i is 2'b11, the result is the unsigned product shifted left by one bit, with bit 0 equal to 0. carry_o is bit 15 of the product before the shift.
- R8: In modes 2'b00, 2'b01 and 2'b10, carry_o equals bit 15 of the result.
- R9: zero_o is 1 exactly when the full 16-bit result is zero.
- R10: After reset, busy_o, done_o, the result and the flags are all 0. The result and the flags keep their values in every cycle in which done_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe |
| mode_i | input | 2 | 00 unsigned, 01 signed, 10 signed-by-unsigned, 11 fractional |
| op_a_i | input | 8 | First operand |
| op_b_i | input | 8 | Second operand |
| busy_o | output | 1 | Operation in flight |
| done_o | output | 1 | One-cycle result-valid pulse |
| prod_lo_o | output | 8 | Result low byte (register 0) |
| prod_hi_o | output | 8 | Result high byte (register 1) |
| zero_o | output | 1 | Zero flag |
| carry_o | output | 1 | Carry flag |

## Verification
Two events can fall in the same cycle: the completion of one operation and the acceptance of the next. A rejected start can also coincide with an operation in flight.

The bench holds start_i high in every cycle. In the busy cycle it presents inverted operands and a different mode, so an operation is accepted exactly in each done cycle.

Each result is judged against a product computed arithmetically from the operands of the accepted start. Any leakage from the rejected cycle, or any lost back-to-back start, appears as a miscompare or as a missing done pulse.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic [1:0] {
    MODE_UU   = 2'b00,
    MODE_SS   = 2'b01,
    MODE_SU   = 2'b10,
    MODE_FRAC = 2'b11
  } mul_mode_e;
endpackage

// File: rtl/mul_issue.sv
module mul_issue #(
  parameter int DATA_W = 8,
  localparam int PROD_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  mul_pkg::mul_mode_e mode_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  output logic              busy_o,
  output logic              frac_o,
  output logic [PROD_W-1:0] a_ext_o,
  output logic [PROD_W-1:0] b_ext_o
);
  import mul_pkg::*;

  logic              accept;
  logic              a_signed, b_signed;
  logic [PROD_W-1:0] a_ext_d, b_ext_d;

  assign accept   = start_i & ~busy_o;
  assign a_signed = (mode_i == MODE_SS) || (mode_i == MODE_SU);
  assign b_signed = (mode_i == MODE_SS);

  always_comb begin
    a_ext_d = {{DATA_W{a_signed & op_a_i[DATA_W-1]}}, op_a_i};
    b_ext_d = {{DATA_W{b_signed & op_b_i[DATA_W-1]}}, op_b_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      frac_o  <= 1'b0;
      a_ext_o <= '0;
      b_ext_o <= '0;
    end else begin
      busy_o <= accept;
      if (accept) begin
        frac_o  <= (mode_i == MODE_FRAC);
        a_ext_o <= a_ext_d;
        b_ext_o <= b_ext_d;
      end
    end
  end
endmodule

// File: rtl/mul_pp_array.sv
module mul_pp_array #(
  parameter int PROD_W = 16
) (
  input  logic [PROD_W-1:0] a_ext_i,
  input  logic [PROD_W-1:0] b_ext_i,
  output logic [PROD_W-1:0] raw_o
);
  // Sign-extended operands: sum of shifted rows modulo 2^PROD_W is the exact product
  logic [PROD_W-1:0] row [PROD_W];
  logic [PROD_W-1:0] acc [PROD_W+1];

  assign acc[0] = '0;

  for (genvar i = 0; i < PROD_W; i++) begin : g_row
    assign row[i]   = {PROD_W{b_ext_i[i]}} & (a_ext_i << i);
    assign acc[i+1] = acc[i] + row[i];
  end

  assign raw_o = acc[PROD_W];
endmodule

// File: rtl/mul_finish.sv
module mul_finish #(
  parameter int PROD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              frac_i,
  input  logic [PROD_W-1:0] raw_i,
  output logic              done_o,
  output logic [PROD_W-1:0] res_o,
  output logic              zero_o,
  output logic              carry_o
);
  logic [PROD_W-1:0] res_d;

  assign res_d = frac_i ? {raw_i[PROD_W-2:0], 1'b0} : raw_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o  <= 1'b0;
      res_o   <= '0;
      zero_o  <= 1'b0;
      carry_o <= 1'b0;
    end else begin
      done_o <= valid_i;
      if (valid_i) begin
        res_o   <= res_d;
        zero_o  <= (res_d == '0);
        carry_o <= raw_i[PROD_W-1];
      end
    end
  end
endmodule

// File: rtl/mul8x8_core.sv
module mul8x8_core #(
  parameter int DATA_W = 8,
  localparam int PROD_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] prod_lo_o,
  output logic [DATA_W-1:0] prod_hi_o,
  output logic              zero_o,
  output logic              carry_o
);
  import mul_pkg::*;

  logic              frac_q;
  logic [PROD_W-1:0] a_ext, b_ext, raw, res;

  mul_issue #(.DATA_W(DATA_W)) u_issue (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .mode_i  (mul_mode_e'(mode_i)),
    .op_a_i  (op_a_i),
    .op_b_i  (op_b_i),
    .busy_o  (busy_o),
    .frac_o  (frac_q),
    .a_ext_o (a_ext),
    .b_ext_o (b_ext)
  );

  mul_pp_array #(.PROD_W(PROD_W)) u_pp (
    .a_ext_i (a_ext),
    .b_ext_i (b_ext),
    .raw_o   (raw)
  );

  mul_finish #(.PROD_W(PROD_W)) u_fin (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (busy_o),
    .frac_i  (frac_q),
    .raw_i   (raw),
    .done_o  (done_o),
    .res_o   (res),
    .zero_o  (zero_o),
    .carry_o (carry_o)
  );

  assign prod_lo_o = res[DATA_W-1:0];
  assign prod_hi_o = res[PROD_W-1:DATA_W];
endmodule

// File: rtl/mul8x8_chk.sv
module mul8x8_chk #(
  parameter int DATA_W = 8,
  localparam int PROD_W = 2 * DATA_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [1:0]        mode_i,
  input logic [DATA_W-1:0] op_a_i,
  input logic [DATA_W-1:0] op_b_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [DATA_W-1:0] prod_lo_o,
  input logic [DATA_W-1:0] prod_hi_o,
  input logic              zero_o,
  input logic              carry_o
);
  logic [PROD_W-1:0] res;
  assign res = {prod_hi_o, prod_lo_o};

  // R1
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o ##1 done_o);

  // R2
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !busy_o);

  // R1
  done_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(busy_o) && !busy_o || $past(busy_o)));

  // R4
  unsigned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(mode_i, 2) == 2'b00) |->
      res == PROD_W'($past(op_a_i, 2)) * PROD_W'($past(op_b_i, 2)));

  // R8
  carry_int_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(mode_i, 2) != 2'b11) |-> carry_o == prod_hi_o[DATA_W-1]);

  // R7
  frac_lsb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(mode_i, 2) == 2'b11) |-> !prod_lo_o[0]);

  // R9
  zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> zero_o == (res == '0));

  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(res) && $stable(zero_o) && $stable(carry_o)));
endmodule

bind mul8x8_core mul8x8_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .mode_i    (mode_i),
  .op_a_i    (op_a_i),
  .op_b_i    (op_b_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .prod_lo_o (prod_lo_o),
  .prod_hi_o (prod_hi_o),
  .zero_o    (zero_o),
  .carry_o   (carry_o)
);

// File: tb/sim_mul8x8_core.sv
module sim_mul8x8_core;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic       start_i;
  logic [1:0] mode_i;
  logic [7:0] op_a_i, op_b_i;
  logic       busy_o, done_o, zero_o, carry_o;
  logic [7:0] prod_lo_o, prod_hi_o;

  int n_vec = 0;
  int n_bad = 0;
  logic [17:0] last_exp = '0;

  always #5 clk = ~clk;

  mul8x8_core u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .op_a_i(op_a_i), .op_b_i(op_b_i), .busy_o(busy_o), .done_o(done_o),
    .prod_lo_o(prod_lo_o), .prod_hi_o(prod_hi_o), .zero_o(zero_o), .carry_o(carry_o)
  );

  // returns {zero, carry, result}
  function automatic logic [17:0] expect_f(logic [7:0] a, logic [7:0] b, logic [1:0] m);
    int sa, sb, p;
    logic [31:0] pv;
    logic [15:0] r;
    logic c;
    sa = a[7] ? int'(a) - 256 : int'(a);
    sb = b[7] ? int'(b) - 256 : int'(b);
    case (m)
      2'b00:   p = int'(a) * int'(b);
      2'b01:   p = sa * sb;
      2'b10:   p = sa * int'(b);
      default: p = int'(a) * int'(b);
    endcase
    pv = p;
    if (m == 2'b11) begin
      r = {pv[14:0], 1'b0};
      c = pv[15];
    end else begin
      r = pv[15:0];
      c = r[15];
    end
    return {(r == 16'h0), c, r};
  endfunction

  function automatic logic [17:0] actual_f();
    return {zero_o, carry_o, prod_hi_o, prod_lo_o};
  endfunction

  task automatic check(string req, logic [17:0] act, logic [17:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%05h expected=%05h", req, act, exp);
    end
  endtask

  function automatic string mode_req(logic [1:0] m);
    case (m)
      2'b00:   return "R4/R3/R8/R9";
      2'b01:   return "R5/R3/R8/R9";
      2'b10:   return "R6/R3/R8/R9";
      default: return "R7/R3/R9";
    endcase
  endfunction

  // start held high through the busy cycle with disturbed inputs (R2)
  task automatic do_op(logic [7:0] a, logic [7:0] b, logic [1:0] m);
    start_i = 1'b1; op_a_i = a; op_b_i = b; mode_i = m;
    @(negedge clk);
    check("R1 busy", {16'h0, busy_o, done_o}, {16'h0, 2'b10});
    op_a_i = ~a; op_b_i = b ^ 8'h5A; mode_i = m + 2'd1;
    @(negedge clk);
    check("R1 done", {16'h0, busy_o, done_o}, {16'h0, 2'b01});
    last_exp = expect_f(a, b, m);
    check(mode_req(m), actual_f(), last_exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] b;
    rst_ni = 1'b0; start_i = 1'b0; mode_i = 2'b00; op_a_i = '0; op_b_i = '0;
    repeat (3) @(negedge clk);
    check("R10 reset", {actual_f()[17:2], busy_o, done_o} , '0);
    check("R10 reset flags", {16'h0, zero_o, carry_o}, '0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int m = 0; m < 4; m++) begin
      for (int a = 0; a < 256; a++) begin
        for (int bi = 0; bi < 20; bi++) begin
          case (bi)
            16:      b = 8'h7F;
            17:      b = 8'h80;
            18:      b = 8'h01;
            19:      b = 8'hFF;
            default: b = 8'(bi * 17);
          endcase
          do_op(8'(a), b, 2'(m));
        end
      end
    end

    // R10: idle cycles with changing inputs keep the last result and flags
    start_i = 1'b0;
    for (int k = 0; k < 5; k++) begin
      op_a_i = 8'(k * 37); op_b_i = 8'(k * 91); mode_i = 2'(k);
      @(negedge clk);
      check("R10 hold", actual_f(), last_exp);
      check("R10 idle", {16'h0, busy_o, done_o}, '0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule